// File: doc/BRIEF.md
# APB to pipelined CSR bridge

This block sits between an APB requester and a shared, pipelined register bus. Each APB transfer becomes exactly one register-bus request. The upper half of the APB address picks the target and the lower half picks the register inside that target. The write flag and the write data are carried over unchanged.

The bridge raises its request and holds it until some target acknowledges. It then withdraws the request. For a read, it completes when the returned data is flagged valid. For a write, it completes once the acknowledge has fallen. The APB wait state lasts through this whole exchange, and ready is given for a single cycle when the exchange ends.

The response may be the wire-OR of several targets, so a quiet, all-zero response simply means that no target is answering. A new request is never launched while the acknowledge from the previous one is still high.

Top module: `apb_csr_bridge`

## Requirements
- R1: While the asynchronous active-low reset is held, req_valid, pready, pslverr and prdata are all 0.
- R2: When the bridge is idle and samples psel high with rsp_ack low, it drives req_valid high in the next cycle. In that cycle req_sel equals paddr[31:16], req_addr equals paddr[15:0] and req_rd equals the inverse of pwrite. req_data equals pwdata for a write and 0 for a read.
- R3: req_valid and all request fields stay unchanged while rsp_ack is sampled low. The cycle after rsp_ack is sampled high, req_valid is 0.
- R4: A request starts only on an edge where rsp_ack is sampled low. An APB transfer that arrives while the previous acknowledge is still high waits with req_valid at 0.
- R5: A write completes with pready high in the cycle after rsp_ack is first sampled low following the drop of req_valid. In that cycle prdata is 0 and pslverr is 0.
- R6: A read completes with pready high in the cycle after rsp_rvalid is sampled high while the read is outstanding, or after the withdrawal if the data came earlier. prdata then equals the rsp_rdata captured with that rsp_rvalid.
- R7: If rsp_rerr is high together with the captured rsp_rvalid, the read completes with pslverr 1 and prdata equal to the returned data. pslverr is 0 on every other cycle.
- R8: pready is high for exactly one cycle per transfer and never while req_valid is high. prdata is 0 whenever pready is low.
- R9: rsp_rvalid, rsp_rdata and rsp_rerr are ignored when no read is outstanding. They start nothing, and a following write still completes with prdata 0 and pslverr 0.
- R10: If rsp_rvalid arrives in the same cycle as the first rsp_ack, the read completes two cycles later with that data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write flag (1 write, 0 read) |
| paddr | input | 32 | APB address: [31:16] target select, [15:0] register |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data, valid with pready |
| pready | output | 1 | APB transfer complete |
| pslverr | output | 1 | APB error, set on a read error |
| req_valid | output | 1 | Register-bus request valid |
| req_rd | output | 1 | Request is a read (1) or write (0) |
| req_sel | output | 16 | Target select |
| req_addr | output | 16 | Register address within the target |
| req_data | output | 32 | Write data (0 for reads) |
| rsp_ack | input | 1 | Wire-ORed acknowledge from targets |
| rsp_rvalid | input | 1 | Read data valid |
| rsp_rdata | input | 32 | Read data |
| rsp_rerr | input | 1 | Read error, qualified by rsp_rvalid |

## Verification
Two pairs of events can fall on the same clock edge. The first pair is the first acknowledge arriving together with the read data, which withdraws the request and captures the data at once. The bench provokes this with a target mode that pulses rsp_rvalid on the very edge where rsp_ack rises. The second pair is the completion of one transfer while the acknowledge is still held high, followed at once by the setup of the next transfer. The bench provokes this by holding rsp_ack for several cycles after a read has already delivered its data, and then starting a write immediately. In both cases a cycle-by-cycle behavioural model predicts every output. The bench also checks that a request only ever rises on an edge where rsp_ack was sampled low.

// File: rtl/apb_csr_pkg.sv
package apb_csr_pkg;

  typedef enum logic [1:0] {
    PH_IDLE    = 2'd0,
    PH_ISSUE   = 2'd1,
    PH_RELEASE = 2'd2,
    PH_DONE    = 2'd3
  } phase_t;

endpackage

// File: rtl/apb_csr_seq.sv
module apb_csr_seq
  import apb_csr_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   apb_sel,
  input  logic   is_read,
  input  logic   have_data,
  input  logic   rsp_ack,
  input  logic   rsp_rvalid,
  output phase_t phase,
  output logic   start_evt,
  output logic   ack_evt,
  output logic   rd_done_evt,
  output logic   wr_done_evt
);

  phase_t phase_q;
  phase_t phase_d;

  assign start_evt   = (phase_q == PH_IDLE) && apb_sel && !rsp_ack;
  assign ack_evt     = (phase_q == PH_ISSUE) && rsp_ack;
  assign rd_done_evt = (phase_q == PH_RELEASE) && is_read && (have_data || rsp_rvalid);
  assign wr_done_evt = (phase_q == PH_RELEASE) && !is_read && !rsp_ack;

  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      PH_IDLE:    if (start_evt) phase_d = PH_ISSUE;
      PH_ISSUE:   if (ack_evt) phase_d = PH_RELEASE;
      PH_RELEASE: if (rd_done_evt || wr_done_evt) phase_d = PH_DONE;
      PH_DONE:    phase_d = PH_IDLE;
      default:    phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
    end else begin
      phase_q <= phase_d;
    end
  end

  assign phase = phase_q;

endmodule

// File: rtl/apb_csr_req_reg.sv
module apb_csr_req_reg #(
  parameter int ADDR_W = 32,
  parameter int SEL_W  = 16,
  parameter int REG_W  = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] paddr,
  input  logic              pwrite,
  input  logic [DATA_W-1:0] pwdata,
  output logic              req_rd,
  output logic [SEL_W-1:0]  req_sel,
  output logic [REG_W-1:0]  req_addr,
  output logic [DATA_W-1:0] req_data
);

  localparam int SEL_LSB = REG_W;

  function automatic logic [SEL_W-1:0] target_of(input logic [ADDR_W-1:0] a);
    return a[SEL_LSB +: SEL_W];
  endfunction

  function automatic logic [REG_W-1:0] register_of(input logic [ADDR_W-1:0] a);
    return a[REG_W-1:0];
  endfunction

  function automatic logic [DATA_W-1:0] payload_of(input logic wr,
                                                   input logic [DATA_W-1:0] d);
    return wr ? d : '0;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_rd   <= 1'b0;
      req_sel  <= '0;
      req_addr <= '0;
      req_data <= '0;
    end else if (load) begin
      req_rd   <= !pwrite;
      req_sel  <= target_of(paddr);
      req_addr <= register_of(paddr);
      req_data <= payload_of(pwrite, pwdata);
    end
  end

endmodule

// File: rtl/apb_csr_rsp_cap.sv
module apb_csr_rsp_cap #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              capture,
  input  logic [DATA_W-1:0] rsp_rdata,
  input  logic              rsp_rerr,
  output logic              have_data,
  output logic [DATA_W-1:0] data_q,
  output logic              err_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_data <= 1'b0;
      data_q    <= '0;
      err_q     <= 1'b0;
    end else if (clear) begin
      have_data <= 1'b0;
      data_q    <= '0;
      err_q     <= 1'b0;
    end else if (capture) begin
      have_data <= 1'b1;
      data_q    <= rsp_rdata;
      err_q     <= rsp_rerr;
    end
  end

endmodule

// File: rtl/apb_csr_bridge.sv
module apb_csr_bridge
  import apb_csr_pkg::*;
#(
  parameter int SEL_W  = 16,
  parameter int REG_W  = 16,
  parameter int DATA_W = 32,
  localparam int ADDR_W = SEL_W + REG_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  output logic [DATA_W-1:0] prdata,
  output logic              pready,
  output logic              pslverr,
  output logic              req_valid,
  output logic              req_rd,
  output logic [SEL_W-1:0]  req_sel,
  output logic [REG_W-1:0]  req_addr,
  output logic [DATA_W-1:0] req_data,
  input  logic              rsp_ack,
  input  logic              rsp_rvalid,
  input  logic [DATA_W-1:0] rsp_rdata,
  input  logic              rsp_rerr
);

  phase_t            phase;
  logic              start_evt;
  logic              ack_evt;
  logic              rd_done_evt;
  logic              wr_done_evt;
  logic              outstanding;
  logic              capture_evt;
  logic              have_data;
  logic [DATA_W-1:0] data_q;
  logic              err_q;

  apb_csr_seq u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .apb_sel     (psel),
    .is_read     (req_rd),
    .have_data   (have_data),
    .rsp_ack     (rsp_ack),
    .rsp_rvalid  (rsp_rvalid),
    .phase       (phase),
    .start_evt   (start_evt),
    .ack_evt     (ack_evt),
    .rd_done_evt (rd_done_evt),
    .wr_done_evt (wr_done_evt)
  );

  apb_csr_req_reg #(
    .ADDR_W (ADDR_W),
    .SEL_W  (SEL_W),
    .REG_W  (REG_W),
    .DATA_W (DATA_W)
  ) u_req (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (start_evt),
    .paddr    (paddr),
    .pwrite   (pwrite),
    .pwdata   (pwdata),
    .req_rd   (req_rd),
    .req_sel  (req_sel),
    .req_addr (req_addr),
    .req_data (req_data)
  );

  assign outstanding = (phase == PH_ISSUE) || (phase == PH_RELEASE);
  assign capture_evt = outstanding && req_rd && rsp_rvalid && !have_data;

  apb_csr_rsp_cap #(
    .DATA_W (DATA_W)
  ) u_cap (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (start_evt),
    .capture   (capture_evt),
    .rsp_rdata (rsp_rdata),
    .rsp_rerr  (rsp_rerr),
    .have_data (have_data),
    .data_q    (data_q),
    .err_q     (err_q)
  );

  assign req_valid = (phase == PH_ISSUE);
  assign pready    = (phase == PH_DONE) && penable;
  assign prdata    = pready ? data_q : '0;
  assign pslverr   = pready && err_q;

endmodule

module apb_csr_bridge_chk #(
  parameter int SEL_W  = 16,
  parameter int REG_W  = 16,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              psel,
  input logic              req_valid,
  input logic              req_rd,
  input logic [SEL_W-1:0]  req_sel,
  input logic [REG_W-1:0]  req_addr,
  input logic [DATA_W-1:0] req_data,
  input logic              rsp_ack,
  input logic              rsp_rvalid,
  input logic              pready,
  input logic              pslverr,
  input logic              start_evt,
  input logic              ack_evt,
  input logic              rd_done_evt,
  input logic              wr_done_evt
);

  AST_START_RAISES_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> req_valid); // R2

  AST_VALID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !rsp_ack |=> req_valid); // R3

  AST_REQ_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !rsp_ack |=> $stable(req_sel) && $stable(req_addr)
                              && $stable(req_data) && $stable(req_rd)); // R3

  AST_VALID_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && rsp_ack |=> !req_valid); // R3

  AST_ACK_WITHDRAW: assert property (@(posedge clk) disable iff (!rst_n)
    ack_evt |=> !req_valid && !pready); // R3

  AST_START_ACK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_valid) |-> $past(!rsp_ack) && $past(psel)); // R4

  AST_WR_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_done_evt |-> !rsp_ack && !req_rd && !req_valid); // R5

  AST_RD_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_done_evt |-> req_rd && !req_valid); // R6

  AST_ERR_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    pslverr |-> pready && req_rd); // R7

  AST_READY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    pready |=> !pready); // R8

  AST_NO_READY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> !pready); // R8

  AST_IDLE_RV_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    !psel && !req_valid && !pready && rsp_rvalid |=> !pready && !req_valid); // R9

endmodule

bind apb_csr_bridge apb_csr_bridge_chk #(
  .SEL_W  (SEL_W),
  .REG_W  (REG_W),
  .DATA_W (DATA_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .psel        (psel),
  .req_valid   (req_valid),
  .req_rd      (req_rd),
  .req_sel     (req_sel),
  .req_addr    (req_addr),
  .req_data    (req_data),
  .rsp_ack     (rsp_ack),
  .rsp_rvalid  (rsp_rvalid),
  .pready      (pready),
  .pslverr     (pslverr),
  .start_evt   (start_evt),
  .ack_evt     (ack_evt),
  .rd_done_evt (rd_done_evt),
  .wr_done_evt (wr_done_evt)
);

// File: tb/apb_csr_bridge_test.sv
`timescale 1ns/1ps
module apb_csr_bridge_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [31:0] paddr = '0, pwdata = '0;
  logic [31:0] prdata;
  logic        pready, pslverr;
  logic        req_valid, req_rd;
  logic [15:0] req_sel, req_addr;
  logic [31:0] req_data;
  logic        rsp_ack = 1'b0, rsp_rvalid = 1'b0, rsp_rerr = 1'b0;
  logic [31:0] rsp_rdata = '0;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  apb_csr_bridge uut (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
    .pslverr(pslverr), .req_valid(req_valid), .req_rd(req_rd),
    .req_sel(req_sel), .req_addr(req_addr), .req_data(req_data),
    .rsp_ack(rsp_ack), .rsp_rvalid(rsp_rvalid), .rsp_rdata(rsp_rdata),
    .rsp_rerr(rsp_rerr)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // target responder, driven on falling edges
  int          t_ack_dly = 0, t_ack_hold = 0, t_rv_mode = 1;
  logic [31:0] t_rdata = '0;
  logic        t_rerr = 1'b0, t_junk = 1'b0;
  int          t_ph = 0, t_cnt = 0;

  always @(negedge clk) begin
    rsp_rvalid = 1'b0;
    rsp_rerr   = 1'b0;
    rsp_rdata  = '0;
    if (!rst_n) begin
      rsp_ack = 1'b0;
      t_ph    = 0;
    end else begin
      case (t_ph)
        0: if (req_valid) begin
             if (t_ack_dly == 0) t_ph = 9; else begin t_cnt = t_ack_dly; t_ph = 1; end
           end else if (t_junk) begin
             rsp_rvalid = 1'b1; rsp_rdata = 32'hDEAD_BEEF; rsp_rerr = 1'b1;
           end
        1: begin t_cnt--; if (t_cnt == 0) t_ph = 9; end
        2: if (!req_valid) begin
             if (req_rd && t_rv_mode == 1) begin
               rsp_rvalid = 1'b1; rsp_rdata = t_rdata; rsp_rerr = t_rerr;
             end
             if (t_ack_hold == 0) begin rsp_ack = 1'b0; t_ph = 0; end
             else begin t_cnt = t_ack_hold; t_ph = 3; end
           end
        3: begin t_cnt--; if (t_cnt == 0) begin rsp_ack = 1'b0; t_ph = 0; end end
        default: t_ph = 0;
      endcase
      if (t_ph == 9) begin
        rsp_ack = 1'b1;
        t_ph    = 2;
        if (req_rd && t_rv_mode == 0) begin
          rsp_rvalid = 1'b1; rsp_rdata = t_rdata; rsp_rerr = t_rerr;
        end
      end
    end
  end

  // behavioural reference, advanced on each rising edge
  int          m_ph = 0;
  logic [15:0] e_sel, e_addr;
  logic [31:0] e_data, e_rdat;
  logic        e_rd, e_got, e_err, e_ack_edge, prev_valid;
  bit          e_done;

  always @(posedge clk) begin
    e_ack_edge = rsp_ack;
    if (!rst_n) begin
      m_ph = 0; e_got = 0; e_rdat = 0; e_err = 0; e_rd = 0;
    end else begin
      case (m_ph)
        0: if (psel && !rsp_ack) begin
             m_ph = 1; e_sel = paddr[31:16]; e_addr = paddr[15:0];
             e_rd = !pwrite; e_data = pwrite ? pwdata : 32'h0;
             e_got = 0; e_rdat = 0; e_err = 0;
           end
        1: begin
             if (e_rd && rsp_rvalid && !e_got) begin e_got = 1; e_rdat = rsp_rdata; e_err = rsp_rerr; end
             if (rsp_ack) m_ph = 2;
           end
        2: begin
             e_done = e_rd ? (e_got || rsp_rvalid) : !rsp_ack;
             if (e_rd && rsp_rvalid && !e_got) begin e_got = 1; e_rdat = rsp_rdata; e_err = rsp_rerr; end
             if (e_done) m_ph = 3;
           end
        default: m_ph = 0;
      endcase
    end
  end

  always @(posedge clk) begin
    #1;
    cycles++;
    if (rst_n) begin
      check(req_valid == (m_ph == 1), "R3 req_valid", req_valid, m_ph == 1);
      check(pready == (m_ph == 3), "R8 pready", pready, m_ph == 3);
      check(prdata == ((m_ph == 3) ? e_rdat : 32'h0), "R6 prdata", prdata,
            (m_ph == 3) ? e_rdat : 32'h0);
      check(pslverr == ((m_ph == 3) && e_err), "R7 pslverr", pslverr,
            (m_ph == 3) && e_err);
      if (m_ph == 1) begin
        check(req_sel == e_sel && req_addr == e_addr, "R2 sel/addr",
              {req_sel, req_addr}, {e_sel, e_addr});
        check(req_rd == e_rd && req_data == e_data, "R2 rd/data", req_data, e_data);
      end
      if (req_valid && !prev_valid)
        check(e_ack_edge == 1'b0, "R4 start with ack low", e_ack_edge, 0);
    end
    prev_valid = req_valid;
  end

  task automatic xfer(input bit wr, input logic [31:0] a, input logic [31:0] d,
                      output logic [31:0] rd, output logic err);
    psel = 1'b1; penable = 1'b0; pwrite = wr; paddr = a; pwdata = d;
    @(negedge clk);
    penable = 1'b1;
    @(negedge clk);
    while (!pready) @(negedge clk);
    rd = prdata; err = pslverr;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0;
  endtask

  always @(posedge clk) begin
    if (cycles > 100000) begin
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 100000);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    logic        e;
    repeat (3) @(negedge clk);
    check(req_valid == 0 && pready == 0, "R1 valid/ready in reset", {req_valid, pready}, 0);
    check(prdata == 0 && pslverr == 0, "R1 data/err in reset", prdata, 0);
    rst_n = 1'b1;
    @(negedge clk);

    t_ack_dly = 2; t_ack_hold = 0;
    xfer(1, 32'h0003_0010, 32'h1234_5678, r, e);
    check(r == 0 && e == 0, "R5 write result", {r[30:0], e}, 0);

    t_ack_dly = 0; t_ack_hold = 3;
    xfer(1, 32'hA5A5_FFFC, 32'hFFFF_0000, r, e);
    check(r == 0 && e == 0, "R5 write with long ack", {r[30:0], e}, 0);
    repeat (4) @(negedge clk);

    t_ack_hold = 0; t_rv_mode = 1; t_rdata = 32'hCAFE_0001; t_rerr = 0;
    xfer(0, 32'h0001_0004, 32'h5555_5555, r, e);
    check(r == 32'hCAFE_0001 && e == 0, "R6 read data", r, 32'hCAFE_0001);

    t_rv_mode = 0; t_ack_dly = 1; t_rdata = 32'h0000_00A5;
    xfer(0, 32'h0002_0008, 0, r, e);
    check(r == 32'h0000_00A5 && e == 0, "R10 data with first ack", r, 32'h0000_00A5);

    t_rv_mode = 1; t_rdata = 32'h0BAD_0BAD; t_rerr = 1;
    xfer(0, 32'h0007_0100, 0, r, e);
    check(r == 32'h0BAD_0BAD, "R7 error data", r, 32'h0BAD_0BAD);
    check(e == 1, "R7 error flag", e, 1);

    t_rerr = 0; t_rdata = 32'h0000_1111; t_ack_hold = 6;
    xfer(0, 32'h0009_0020, 0, r, e);
    check(r == 32'h0000_1111, "R4 read before held ack", r, 32'h0000_1111);
    psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = 32'h0009_0024; pwdata = 32'h77;
    @(negedge clk);
    penable = 1'b1;
    repeat (2) begin
      @(negedge clk);
      check(req_valid == 0 && rsp_ack == 1, "R4 held off by ack", {req_valid, rsp_ack}, 1);
    end
    while (!pready) @(negedge clk);
    check(prdata == 0, "R5 deferred write", prdata, 0);
    @(negedge clk);
    psel = 1'b0; penable = 1'b0;
    repeat (8) @(negedge clk);

    t_ack_hold = 0; t_junk = 1;
    repeat (5) @(negedge clk);
    check(req_valid == 0 && pready == 0, "R9 idle junk ignored", {req_valid, pready}, 0);
    xfer(1, 32'h0004_0040, 32'h0F0F_0F0F, r, e);
    check(r == 0 && e == 0, "R9 write after junk", {r[30:0], e}, 0);
    t_junk = 0;
    repeat (2) @(negedge clk);

    for (int i = 0; i < 24; i++) begin
      t_ack_dly  = i % 3;
      t_ack_hold = (i / 3) % 3;
      t_rv_mode  = i % 2;
      t_rdata    = 32'h1000_0000 + 32'(i * 17);
      t_rerr     = (i % 5 == 0);
      xfer(i % 4 == 0, {16'(i), 16'(i * 4)}, 32'(i * 257), r, e);
      if (i % 4 == 0)
        check(r == 0 && e == 0, "R5 loop write", {r[30:0], e}, 0);
      else
        check(r == t_rdata && e == t_rerr, "R6 loop read", r, t_rdata);
    end
    repeat (5) @(negedge clk);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule